// File: doc/BRIEF.md
# Configuration Access Byte-Lane Generator

This block sits between a host-side request port and the register space of a root-port controller. It turns one configuration read or write into two accesses on a simple register master: first a header word naming the target bus, device/function and active byte lanes is written to a fixed header register, then a word-aligned access is made into a memory-mapped configuration window. Narrow writes are moved onto the lanes they target, and the word returned by a read is moved back down to bit 0 and cut to the requested width.

A request is accepted in any cycle where the block is idle. It then runs a fixed schedule: header write, window access, one cycle to capture the read word, and a single-cycle completion pulse. Access sizes other than 1, 2 or 4 bytes make no bus access and complete with an error flag.

Top module: `cfg_lane_gen`

## Requirements
- R1: The header word has device/function in bits 7:0, bus number in bits 15:8, byte enables in bits 19:16, bit 20 always 1 and bits 31:21 zero.
- R2: Byte enables equal (2^size − 1) shifted left by offset[1:0], truncated to 4 bits (a 2-byte access at offset 3 gives 4'b1000; a 4-byte access at offset 2 gives 4'b1100).
- R3: Write data is masked to the access size; for 1- and 2-byte writes it is shifted left by 8 × offset[1:0]; 4-byte writes are issued unshifted.
- R4: The header write goes to BASE_ADDR + HDR_OFS (default 0x140); the window access goes to BASE_ADDR + WIN_OFS (default 0x1000) plus the offset with its two low bits cleared.
- R5: The cycle after acceptance carries the header write (strobe high, write high); the next cycle carries the window access, whose write flag follows the request.
- R6: On a read, the word on the read-data input in the cycle after the window access is shifted right by 8 × offset[1:0], masked to the access size, and held on rdata until the next successful read; writes and errors leave rdata unchanged.
- R7: done is a one-cycle pulse in the fourth cycle after acceptance, with err low for a legal size.
- R8: A size other than 1, 2 or 4 makes no strobe and raises done with err high in the second cycle after acceptance.
- R9: busy is high from the cycle after acceptance until done; requests presented while busy are ignored.
- R10: During and right after reset, busy, done, err, the strobe, the address, the write data and rdata are all zero.
- R11: A request presented in the cycle that done is high is accepted; its header follows in the next cycle while rdata keeps the previous result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Target device/function number |
| req_offset | input | OFS_W | Byte offset in configuration space |
| req_size | input | 3 | Access size in bytes (1, 2 or 4) |
| req_wdata | input | 32 | Write data, right-aligned |
| busy | output | 1 | A request is in flight |
| mst_en | output | 1 | Register-master access strobe |
| mst_we | output | 1 | Register-master write flag |
| mst_addr | output | ADDR_W | Register-master address |
| mst_wdata | output | 32 | Register-master write data |
| mst_rdata | input | 32 | Register-master read data, one cycle after a read strobe |
| done | output | 1 | Completion pulse |
| err | output | 1 | Illegal size, valid with done |
| rdata | output | 32 | Extracted read result |

## Verification
Completion of one request and acceptance of the next can fall in the same cycle. The bench chains every table entry so that each new request is presented exactly in the cycle its predecessor raises done, then checks that done is still high there, that the following cycle shows the new header with done low, and that rdata still holds the previous read result. One directed case also presents a request while busy and checks that the window access and the cycle after done carry no trace of it.

// File: rtl/cfg_lane_pkg.sv
package cfg_lane_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_WIN  = 2'd2,
    ST_RESP = 2'd3
  } seq_state_e;

  localparam int unsigned FORCE_BE_BIT = 20;

  function automatic logic size_legal(input logic [2:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction

  function automatic logic [31:0] size_mask(input logic [2:0] sz);
    case (sz)
      3'd1:    return 32'h0000_00FF;
      3'd2:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/cfg_hdr_build.sv
module cfg_hdr_build
  import cfg_lane_pkg::*;
(
  input  logic [7:0]  bus_i,
  input  logic [7:0]  devfn_i,
  input  logic [1:0]  off_lo_i,
  input  logic [2:0]  size_i,
  output logic [31:0] hdr_o
);

  logic [3:0] lane_mask;
  logic [3:0] be;

  always_comb begin
    case (size_i)
      3'd1:    lane_mask = 4'b0001;
      3'd2:    lane_mask = 4'b0011;
      3'd4:    lane_mask = 4'b1111;
      default: lane_mask = 4'b0000;
    endcase
    be = lane_mask << off_lo_i;
  end

  always_comb begin
    hdr_o = '0;
    hdr_o[7:0]          = devfn_i;
    hdr_o[15:8]         = bus_i;
    hdr_o[19:16]        = be;
    hdr_o[FORCE_BE_BIT] = 1'b1;
  end

endmodule

// File: rtl/cfg_lane_shift.sv
module cfg_lane_shift
  import cfg_lane_pkg::*;
(
  input  logic [2:0]  size_i,
  input  logic [1:0]  off_lo_i,
  input  logic [31:0] wdata_i,
  input  logic [31:0] rword_i,
  output logic [31:0] wdata_o,
  output logic [31:0] rdata_o
);

  logic [31:0] dmask;
  logic [4:0]  lane_sh;
  logic [4:0]  wr_sh;

  always_comb begin
    dmask   = size_mask(size_i);
    lane_sh = {off_lo_i, 3'b000};
    wr_sh   = (size_i == 3'd4) ? 5'd0 : lane_sh;
    wdata_o = (wdata_i & dmask) << wr_sh;
    rdata_o = (rword_i >> lane_sh) & dmask;
  end

endmodule

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm
  import cfg_lane_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept_i,
  input  logic       legal_i,
  output seq_state_e state_o,
  output logic       done_o
);

  seq_state_e state_q, state_d;
  logic       done_q, done_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (accept_i) state_d = legal_i ? ST_HDR : ST_RESP;
      ST_HDR:  state_d = ST_WIN;
      ST_WIN:  state_d = ST_RESP;
      default: state_d = ST_IDLE;
    endcase
    done_d = (state_q == ST_RESP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign state_o = state_q;
  assign done_o  = done_q;

endmodule

// File: rtl/cfg_lane_gen.sv
module cfg_lane_gen
  import cfg_lane_pkg::*;
#(
  parameter int unsigned        ADDR_W    = 32,
  parameter int unsigned        OFS_W     = 12,
  parameter logic [ADDR_W-1:0]  BASE_ADDR = 32'h4000_0000,
  parameter logic [ADDR_W-1:0]  HDR_OFS   = 32'h0000_0140,
  parameter logic [ADDR_W-1:0]  WIN_OFS   = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [7:0]        req_bus,
  input  logic [7:0]        req_devfn,
  input  logic [OFS_W-1:0]  req_offset,
  input  logic [2:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              busy,
  output logic              mst_en,
  output logic              mst_we,
  output logic [ADDR_W-1:0] mst_addr,
  output logic [31:0]       mst_wdata,
  input  logic [31:0]       mst_rdata,
  output logic              done,
  output logic              err,
  output logic [31:0]       rdata
);

  localparam logic [ADDR_W-1:0] HDR_ADDR = BASE_ADDR + HDR_OFS;
  localparam logic [ADDR_W-1:0] WIN_ADDR = BASE_ADDR + WIN_OFS;
  localparam int unsigned       PAD_W    = ADDR_W - OFS_W;

  seq_state_e state;
  logic       accept;
  logic       fsm_done;

  // captured request
  logic             we_q,    we_d;
  logic [7:0]       bus_q,   bus_d;
  logic [7:0]       devfn_q, devfn_d;
  logic [OFS_W-1:0] off_q,   off_d;
  logic [2:0]       size_q,  size_d;
  logic [31:0]      wd_q,    wd_d;
  logic             ok_q,    ok_d;
  logic             err_q,   err_d;
  logic [31:0]      rd_q,    rd_d;

  logic [31:0] hdr_word;
  logic [31:0] wd_lane;
  logic [31:0] rd_lane;
  logic [ADDR_W-1:0] win_addr;

  assign accept = req_valid && (state == ST_IDLE);

  cfg_seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept),
    .legal_i  (size_legal(req_size)),
    .state_o  (state),
    .done_o   (fsm_done)
  );

  cfg_hdr_build u_hdr (
    .bus_i    (bus_q),
    .devfn_i  (devfn_q),
    .off_lo_i (off_q[1:0]),
    .size_i   (size_q),
    .hdr_o    (hdr_word)
  );

  cfg_lane_shift u_shift (
    .size_i   (size_q),
    .off_lo_i (off_q[1:0]),
    .wdata_i  (wd_q),
    .rword_i  (mst_rdata),
    .wdata_o  (wd_lane),
    .rdata_o  (rd_lane)
  );

  // next-state for request capture and result registers
  always_comb begin
    we_d    = we_q;
    bus_d   = bus_q;
    devfn_d = devfn_q;
    off_d   = off_q;
    size_d  = size_q;
    wd_d    = wd_q;
    ok_d    = ok_q;
    err_d   = err_q;
    rd_d    = rd_q;
    if (accept) begin
      we_d    = req_write;
      bus_d   = req_bus;
      devfn_d = req_devfn;
      off_d   = req_offset;
      size_d  = req_size;
      wd_d    = req_wdata;
      ok_d    = size_legal(req_size);
    end
    if (state == ST_RESP) begin
      err_d = !ok_q;
      if (ok_q && !we_q) rd_d = rd_lane;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      bus_q   <= '0;
      devfn_q <= '0;
      off_q   <= '0;
      size_q  <= '0;
      wd_q    <= '0;
      ok_q    <= 1'b0;
      err_q   <= 1'b0;
      rd_q    <= '0;
    end else begin
      we_q    <= we_d;
      bus_q   <= bus_d;
      devfn_q <= devfn_d;
      off_q   <= off_d;
      size_q  <= size_d;
      wd_q    <= wd_d;
      ok_q    <= ok_d;
      err_q   <= err_d;
      rd_q    <= rd_d;
    end
  end

  assign win_addr = WIN_ADDR + {{PAD_W{1'b0}}, off_q[OFS_W-1:2], 2'b00};

  // register-master drive
  always_comb begin
    mst_en    = 1'b0;
    mst_we    = 1'b0;
    mst_addr  = '0;
    mst_wdata = '0;
    case (state)
      ST_HDR: begin
        mst_en    = 1'b1;
        mst_we    = 1'b1;
        mst_addr  = HDR_ADDR;
        mst_wdata = hdr_word;
      end
      ST_WIN: begin
        mst_en    = 1'b1;
        mst_we    = we_q;
        mst_addr  = win_addr;
        mst_wdata = we_q ? wd_lane : 32'h0;
      end
      default: ;
    endcase
  end

  assign busy  = (state != ST_IDLE);
  assign done  = fsm_done;
  assign err   = fsm_done && err_q;
  assign rdata = rd_q;

endmodule

// File: rtl/cfg_lane_gen_chk.sv
module cfg_lane_gen_chk #(
  parameter int unsigned       ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] HDR_ADDR = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mst_en,
  input logic              mst_we,
  input logic [ADDR_W-1:0] mst_addr,
  input logic [31:0]       mst_wdata,
  input logic              done,
  input logic              err,
  input logic              busy
);

  logic hdr_cyc;
  assign hdr_cyc = mst_en && (mst_addr == HDR_ADDR);

  p_hdr_layout_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_cyc |-> (mst_wdata[20] && (mst_wdata[31:21] == 11'd0)))
    else $error("R1 header word layout broken");

  p_be_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_cyc |-> (mst_wdata[19:16] != 4'd0))
    else $error("R2 empty byte enables");

  p_hdr_is_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_cyc |-> mst_we)
    else $error("R5 header access not a write");

  p_win_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_cyc |=> (mst_en && (mst_addr != HDR_ADDR)))
    else $error("R5 window access missing after header");

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done)
    else $error("R7 done longer than one cycle");

  p_err_no_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> !$past(mst_en))
    else $error("R8 error completion after bus access");

  p_idle_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !mst_en))
    else $error("R9 busy or strobe during done");

endmodule

bind cfg_lane_gen cfg_lane_gen_chk #(
  .ADDR_W   (ADDR_W),
  .HDR_ADDR (BASE_ADDR + HDR_OFS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mst_en    (mst_en),
  .mst_we    (mst_we),
  .mst_addr  (mst_addr),
  .mst_wdata (mst_wdata),
  .done      (done),
  .err       (err),
  .busy      (busy)
);

// File: tb/cfg_lane_gen_tb.sv
`timescale 1ns/1ps
module cfg_lane_gen_tb_top;

  typedef struct packed {
    logic        we;
    logic [7:0]  bus;
    logic [7:0]  devfn;
    logic [11:0] off;
    logic [2:0]  size;
    logic [31:0] wd;
    logic [31:0] brd;
    logic [3:0]  be;
    logic [31:0] xwd;
    logic [31:0] xaddr;
    logic [31:0] xrd;
  } vec_t;

  localparam int NV = 9;
  localparam logic [31:0] HDR_A = 32'h4000_0140;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h01, 8'h08, 12'h010, 3'd4, 32'hDEADBEEF, 32'h0, 4'hF, 32'hDEADBEEF, 32'h4000_1010, 32'h0},
    '{1'b1, 8'h02, 8'h11, 12'h005, 3'd1, 32'h000000A5, 32'h0, 4'h2, 32'h0000A500, 32'h4000_1004, 32'h0},
    '{1'b1, 8'h7F, 8'hFA, 12'h02E, 3'd2, 32'hFFFF1234, 32'h0, 4'hC, 32'h12340000, 32'h4000_102C, 32'h0},
    '{1'b1, 8'hFF, 8'h00, 12'h0FF, 3'd2, 32'h0000BEEF, 32'h0, 4'h8, 32'hEF000000, 32'h4000_10FC, 32'h0},
    '{1'b0, 8'h03, 8'h20, 12'h004, 3'd4, 32'h0, 32'h12345678, 4'hF, 32'h0, 32'h4000_1004, 32'h12345678},
    '{1'b0, 8'h04, 8'h21, 12'h00E, 3'd2, 32'h0, 32'hAABBCCDD, 4'hC, 32'h0, 32'h4000_100C, 32'h0000AABB},
    '{1'b0, 8'h05, 8'h22, 12'h003, 3'd1, 32'h0, 32'h11223344, 4'h8, 32'h0, 32'h4000_1000, 32'h00000011},
    '{1'b0, 8'h06, 8'h23, 12'h101, 3'd1, 32'h0, 32'h55667788, 4'h2, 32'h0, 32'h4000_1100, 32'h00000077},
    '{1'b0, 8'h07, 8'h24, 12'h102, 3'd4, 32'h0, 32'hCAFEF00D, 4'hC, 32'h0, 32'h4000_1100, 32'h0000CAFE}
  };

  logic        clk, rst_n;
  logic        req_valid, req_write;
  logic [7:0]  req_bus, req_devfn;
  logic [11:0] req_offset;
  logic [2:0]  req_size;
  logic [31:0] req_wdata;
  logic        busy, mst_en, mst_we, done, err;
  logic [31:0] mst_addr, mst_wdata, mst_rdata, rdata;

  int checks, failures;
  logic [31:0] rd_val;
  logic [31:0] last_rd;

  cfg_lane_gen dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_bus(req_bus), .req_devfn(req_devfn), .req_offset(req_offset),
    .req_size(req_size), .req_wdata(req_wdata), .busy(busy), .mst_en(mst_en),
    .mst_we(mst_we), .mst_addr(mst_addr), .mst_wdata(mst_wdata),
    .mst_rdata(mst_rdata), .done(done), .err(err), .rdata(rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // register-space model: read word appears one cycle after a read strobe
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) mst_rdata <= 32'h0BAD0BAD;
    else        mst_rdata <= (mst_en && !mst_we) ? rd_val : 32'h0BAD0BAD;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input vec_t v);
    req_valid  = 1'b1;
    req_write  = v.we;
    req_bus    = v.bus;
    req_devfn  = v.devfn;
    req_offset = v.off;
    req_size   = v.size;
    req_wdata  = v.wd;
    rd_val     = v.brd;
  endtask

  // caller is at the negedge where the request was driven
  task automatic follow(input vec_t v, input bit poke_busy);
    @(negedge clk);
    req_valid = 1'b0;
    // header cycle
    chk("R5 header strobe", {30'b0, mst_en, mst_we}, 32'h3);
    chk("R4 header address", mst_addr, HDR_A);
    chk("R1 header word", mst_wdata, {11'b0, 1'b1, v.be, v.bus, v.devfn});
    chk("R2 byte enables", {28'b0, mst_wdata[19:16]}, {28'b0, v.be});
    chk("R11 done low and rdata held", {done, rdata[30:0]}, {1'b0, last_rd[30:0]});
    chk("R9 busy", {31'b0, busy}, 32'h1);
    if (poke_busy) begin
      req_valid = 1'b1; req_write = 1'b1; req_bus = 8'hEE; req_size = 3'd1;
      req_offset = 12'h000; req_wdata = 32'h0;
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk("R5 window strobe", {30'b0, mst_en, mst_we}, {30'b0, 1'b1, v.we});
    chk("R4 window address", mst_addr, v.xaddr);
    if (v.we) chk("R3 write lanes", mst_wdata, v.xwd);
    @(negedge clk);
    chk("R7 no strobe before done", {30'b0, mst_en, done}, 32'h0);
    @(negedge clk);
    chk("R7 done and err", {30'b0, done, err}, 32'h2);
    chk("R9 idle at done", {31'b0, busy}, 32'h0);
    if (!v.we) last_rd = v.xrd;
    chk(v.we ? "R6 rdata kept on write" : "R6 read extraction", rdata, last_rd);
  endtask

  initial begin
    checks = 0; failures = 0; last_rd = 32'h0; rd_val = 32'h0;
    req_valid = 1'b0; req_write = 1'b0; req_bus = '0; req_devfn = '0;
    req_offset = '0; req_size = '0; req_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 reset outputs", {28'b0, busy, mst_en, done, err}, 32'h0);
    chk("R10 reset addr", mst_addr, 32'h0);
    chk("R10 reset data", mst_wdata | rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 after release", {29'b0, busy, mst_en, done}, 32'h0);

    // table walk, each request chained onto the previous done cycle
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i]);
      if (i > 0) chk("R11 done in accept cycle", {31'b0, done}, 32'h1);
      follow(VEC[i], 1'b0);
    end

    // illegal sizes
    for (int k = 0; k < 2; k++) begin
      vec_t bad;
      bad = VEC[0];
      bad.size = (k == 0) ? 3'd3 : 3'd0;
      issue(bad);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R8 no strobe on illegal size", {30'b0, mst_en, busy}, 32'h1);
      @(negedge clk);
      chk("R8 done with err", {29'b0, done, err, mst_en}, 32'h6);
      chk("R8 rdata unchanged", rdata, last_rd);
    end

    // request while busy is dropped
    issue(VEC[5]);
    follow(VEC[5], 1'b1);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R9 no extra access", {30'b0, mst_en, busy}, 32'h0);
    @(negedge clk);
    chk("R9 still idle", {29'b0, mst_en, busy, done}, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired act=hung exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule